// File: doc/BRIEF.md
# Translation table base selector

This block sits between a TLB miss and the first-level page-table fetch for a 32-bit virtual address space that is served by two table base registers. The low base register covers a per-process region that starts at address zero. The high base register covers a shared region at the top of the space. For each miss the block decides which base applies and checks that walks through that base are enabled. It then returns either the byte address of the first-level descriptor or a translation fault. It also returns the memory-attribute bits held in the chosen base register.

The block holds three registers, written through a plain write port: a control word and the two base registers. The control word carries a 3-bit split value N and two walk-disable flags. N places the boundary between the two regions. N also sets how wide the low base field is and how many VA bits index the low table. Miss requests enter on a valid/ready stream, and responses leave on a second valid/ready stream through a one-entry output register. The block accepts a new request only when that register is empty or is being drained in the same cycle. A stalled response therefore stops intake, and the stall reaches the requester through `req_ready`.

Top module: `tbase_sel`

## Requirements
- R1: With N = 0 (control bits [2:0]), every request selects the low base register (`rsp_use_hi` = 0), whatever the VA.
- R2: With N from 1 to 7, the high base register is selected exactly when VA bits [31:32-N] are not all zero. The first high address is therefore 0x80000000 >> (N-1).
- R3: For the low base, the descriptor address is base_lo[31:14-N] followed by VA[31-N:20] and two zero bits. Base bits below 14-N are ignored.
- R4: For the high base, the table is always 16 KB. The descriptor address is base_hi[31:14] followed by VA[31:20] and two zero bits, for any N.
- R5: Control bit 4 disables walks through the low base, and control bit 5 disables walks through the high base. A request that selects a disabled base responds with `rsp_fault` = 1 and `rsp_addr` = 0. The other base's flag has no effect on the request.
- R6: `rsp_attr` carries bits [6:0] of the selected base register. This holds for faulting responses too.
- R7: Each accepted request (`req_valid` and `req_ready` high at one edge) gives exactly one response, and that response is valid in the following cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `req_ready` is low.
- R8: A register write in the same cycle as an accepted request does not affect that request's response. It applies to later requests.
- R9: After reset, `rsp_valid` is 0, `req_ready` is 1, and all three registers read as zero in effect (N = 0, both walks enabled, both bases zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 low base, 2 high base |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Miss request accepted when high with req_valid |
| req_va | input | 32 | Virtual address of the miss |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response when high with rsp_valid |
| rsp_fault | output | 1 | Translation fault: walk disabled for the chosen base |
| rsp_use_hi | output | 1 | 1 when the high base was chosen |
| rsp_addr | output | 32 | First-level descriptor byte address (0 on fault) |
| rsp_attr | output | 7 | Walk attribute bits from the chosen base register |

## Verification
The bench builds the block with its default parameters: a 32-bit VA, 1 MB first-level sections, a 3-bit split and 7 attribute bits. With these values every split from 0 to 7 can be reached, together with the smallest low table (128 bytes at N = 7) and the address just below and at each boundary. The vector table covers the splits, both disable flags, and each flag's lack of effect on the other region. Directed tests then cover reset, a response held under back-pressure with a second request waiting, and a write that collides with an accepted request.

// File: rtl/tbsel_pkg.sv
package tbsel_pkg;

  localparam int SPLIT_W = 3;

  typedef struct packed {
    logic               dis_hi;
    logic               dis_lo;
    logic [SPLIT_W-1:0] split;
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_BASE_LO = 2'd1,
    REG_BASE_HI = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/tbsel_regs.sv
module tbsel_regs
  import tbsel_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SPLIT_LSB  = 0,
  parameter int DIS_LO_BIT = 4,
  parameter int DIS_HI_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] base_lo,
  output logic [DATA_W-1:0] base_hi
);

  // Control word fields are picked out of the write data at fixed bits.
  ctrl_t ctrl_next;

  always_comb begin
    ctrl_next.split  = wdata[SPLIT_LSB +: SPLIT_W];
    ctrl_next.dis_lo = wdata[DIS_LO_BIT];
    ctrl_next.dis_hi = wdata[DIS_HI_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      base_lo <= '0;
      base_hi <= '0;
    end else if (we) begin
      case (reg_sel_e'(sel))
        REG_CTRL:    ctrl    <= ctrl_next;
        REG_BASE_LO: base_lo <= wdata;
        REG_BASE_HI: base_hi <= wdata;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/tbsel_route.sv
module tbsel_route
  import tbsel_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int SECT_SHIFT = 20,
  parameter int ATTR_W     = 7
) (
  input  logic [VA_W-1:0]   va,
  input  ctrl_t             ctrl,
  input  logic [VA_W-1:0]   base_lo,
  input  logic [VA_W-1:0]   base_hi,
  output logic              use_hi,
  output logic              fault,
  output logic [VA_W-1:0]   addr,
  output logic [ATTR_W-1:0] attr
);

  localparam int IDX_W    = VA_W - SECT_SHIFT;  // full first-level index width
  localparam int BASE_LSB = IDX_W + 2;          // 4-byte descriptors
  localparam int SH_W     = $clog2(VA_W) + 1;

  localparam logic [VA_W-1:0] ONE = VA_W'(1);

  logic [SH_W-1:0] sh_top, sh_base, sh_idx;
  logic [VA_W-1:0] top_bits;
  logic [VA_W-1:0] keep_lo, keep_hi, idx_mask;
  logic [VA_W-1:0] sect_idx;
  logic [VA_W-1:0] addr_lo, addr_hi;

  always_comb begin
    sh_top  = SH_W'(VA_W)     - SH_W'(ctrl.split);
    sh_base = SH_W'(BASE_LSB) - SH_W'(ctrl.split);
    sh_idx  = SH_W'(IDX_W)    - SH_W'(ctrl.split);

    // Region decision: the top N bits of the VA must be zero for the low base.
    top_bits = va >> sh_top;
    use_hi   = (ctrl.split != '0) && (top_bits != '0);

    // Low table: base field narrows and index shortens as N grows.
    keep_lo  = ~((ONE << sh_base) - ONE);
    idx_mask = (ONE << sh_idx) - ONE;
    sect_idx = va >> SECT_SHIFT;
    addr_lo  = (base_lo & keep_lo) | ((sect_idx & idx_mask) << 2);

    // High table: fixed full-size table.
    keep_hi  = ~((ONE << BASE_LSB) - ONE);
    addr_hi  = (base_hi & keep_hi) | (sect_idx << 2);

    fault = use_hi ? ctrl.dis_hi : ctrl.dis_lo;
    addr  = fault ? '0 : (use_hi ? addr_hi : addr_lo);
    attr  = use_hi ? base_hi[ATTR_W-1:0] : base_lo[ATTR_W-1:0];
  end

endmodule

// File: rtl/tbsel_rsp_stage.sv
module tbsel_rsp_stage #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_fault,
  input  logic              in_use_hi,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ATTR_W-1:0] in_attr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fault,
  output logic              out_use_hi,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ATTR_W-1:0] out_attr
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_fault  <= 1'b0;
      out_use_hi <= 1'b0;
      out_addr   <= '0;
      out_attr   <= '0;
    end else if (take) begin
      out_fault  <= in_fault;
      out_use_hi <= in_use_hi;
      out_addr   <= in_addr;
      out_attr   <= in_attr;
    end
  end

endmodule

// File: rtl/tbase_sel.sv
module tbase_sel
  import tbsel_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int SECT_SHIFT = 20,
  parameter int ATTR_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [VA_W-1:0]   reg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic              rsp_use_hi,
  output logic [VA_W-1:0]   rsp_addr,
  output logic [ATTR_W-1:0] rsp_attr
);

  localparam int BASE_LSB = VA_W - SECT_SHIFT + 2;

  // The narrowest low base field must still sit above the attribute bits.
  generate
    if (BASE_LSB - ((1 << SPLIT_W) - 1) < ATTR_W) begin : g_bad_cfg
      initial $error("attribute bits overlap the narrowest low base field");
    end
  endgenerate

  ctrl_t             ctrl;
  logic [VA_W-1:0]   base_lo, base_hi;
  logic              sel_hi, sel_fault;
  logic [VA_W-1:0]   sel_addr;
  logic [ATTR_W-1:0] sel_attr;

  tbsel_regs #(.DATA_W(VA_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .ctrl    (ctrl),
    .base_lo (base_lo),
    .base_hi (base_hi)
  );

  tbsel_route #(.VA_W(VA_W), .SECT_SHIFT(SECT_SHIFT), .ATTR_W(ATTR_W)) route_i (
    .va      (req_va),
    .ctrl    (ctrl),
    .base_lo (base_lo),
    .base_hi (base_hi),
    .use_hi  (sel_hi),
    .fault   (sel_fault),
    .addr    (sel_addr),
    .attr    (sel_attr)
  );

  tbsel_rsp_stage #(.ADDR_W(VA_W), .ATTR_W(ATTR_W)) rsp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .in_fault   (sel_fault),
    .in_use_hi  (sel_hi),
    .in_addr    (sel_addr),
    .in_attr    (sel_attr),
    .out_valid  (rsp_valid),
    .out_ready  (rsp_ready),
    .out_fault  (rsp_fault),
    .out_use_hi (rsp_use_hi),
    .out_addr   (rsp_addr),
    .out_attr   (rsp_attr)
  );

endmodule

// File: rtl/tbsel_chk.sv
module tbsel_chk #(
  parameter int VA_W   = 32,
  parameter int ATTR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic              rsp_use_hi,
  input logic [VA_W-1:0]   rsp_addr,
  input logic [ATTR_W-1:0] rsp_attr
);

  p_rsp_follows_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)
                                   && $stable(rsp_use_hi) && $stable(rsp_attr)));

  p_no_intake_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

  p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr[1:0] == 2'b00));

  p_idle_after_reset_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> !rsp_valid);

endmodule

bind tbase_sel tbsel_chk #(.VA_W(VA_W), .ATTR_W(ATTR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_fault  (rsp_fault),
  .rsp_use_hi (rsp_use_hi),
  .rsp_addr   (rsp_addr),
  .rsp_attr   (rsp_attr)
);

// File: tb/tbase_sel_tb.sv
module tbase_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE_LO = 32'h1234_5F3A;  // attr 0x3A
  localparam logic [31:0] BASE_HI = 32'h8765_C0C5;  // attr 0x45

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [31:0] va;
    logic        hi;
    logic        fault;
    logic [31:0] addr;
    logic [6:0]  attr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'hFFF0_0000, 1'b0, 1'b0, 32'h1234_7FFC, 7'h3A},  // R1
    '{8'h00, 32'h0010_0000, 1'b0, 1'b0, 32'h1234_4004, 7'h3A},  // R1 R3
    '{8'h01, 32'h7FF0_0000, 1'b0, 1'b0, 32'h1234_5FFC, 7'h3A},  // R2 R3
    '{8'h01, 32'h8000_0000, 1'b1, 1'b0, 32'h8765_E000, 7'h45},  // R2 R4
    '{8'h07, 32'h01F0_0000, 1'b0, 1'b0, 32'h1234_5F7C, 7'h3A},  // R2 R3
    '{8'h07, 32'h0200_0000, 1'b1, 1'b0, 32'h8765_C080, 7'h45},  // R2 R4
    '{8'h03, 32'h1FF0_0000, 1'b0, 1'b0, 32'h1234_5FFC, 7'h3A},  // R3
    '{8'h03, 32'h2000_0000, 1'b1, 1'b0, 32'h8765_C800, 7'h45},  // R4
    '{8'h12, 32'h1000_0000, 1'b0, 1'b1, 32'h0000_0000, 7'h3A},  // R5 R6
    '{8'h12, 32'h4000_0000, 1'b1, 1'b0, 32'h8765_D000, 7'h45},  // R5
    '{8'h22, 32'hC000_0000, 1'b1, 1'b1, 32'h0000_0000, 7'h45},  // R5 R6
    '{8'h22, 32'h3000_0000, 1'b0, 1'b0, 32'h1234_5C00, 7'h3A},  // R5 R3
    '{8'h30, 32'hFFF0_0000, 1'b0, 1'b1, 32'h0000_0000, 7'h3A},  // R1 R5
    '{8'h20, 32'hFFF0_0000, 1'b0, 1'b0, 32'h1234_7FFC, 7'h3A}   // R1 R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic        rsp_use_hi;
  logic [31:0] rsp_addr;
  logic [6:0]  rsp_attr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_sel dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_rsp(input string req, input logic hi, input logic f,
                           input logic [31:0] a, input logic [6:0] at);
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hi"},    32'(rsp_use_hi), 32'(hi));
    check({req, " fault"}, 32'(rsp_fault), 32'(f));
    check({req, " addr"},  rsp_addr, a);
    check({req, " attr"},  32'(rsp_attr), 32'(at));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R9 reset state
    check("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R9 req_ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    // R9: zero registers -> N=0, low base 0
    issue(32'hABC0_0000);
    check_rsp("R9", 1'b0, 1'b0, 32'h0000_2AF0, 7'h00);

    wr(2'd1, BASE_LO);
    wr(2'd2, BASE_HI);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {24'h0, VECS[i].ctrl});
      issue(VECS[i].va);
      check_rsp($sformatf("R1-R6 vector %0d", i), VECS[i].hi, VECS[i].fault,
                VECS[i].addr, VECS[i].attr);
    end

    // R7: back-pressure hold with a second request waiting
    wr(2'd0, 32'h0000_0001);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_va = 32'h0010_0000;
    @(negedge clk);
    req_va = 32'h8000_0000;  // second request, stalled
    for (int k = 0; k < 3; k++) begin
      check("R7 held valid", 32'(rsp_valid), 32'd1);
      check("R7 ready low", 32'(req_ready), 32'd0);
      check("R7 held addr", rsp_addr, 32'h1234_4004);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R7 second", 1'b1, 1'b0, 32'h8765_E000, 7'h45);
    @(negedge clk);
    check("R7 single response", 32'(rsp_valid), 32'd0);

    // R8: write colliding with an accepted request
    wr(2'd0, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h0010_0000;
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'hAAAA_0011;
    @(negedge clk);
    req_valid = 1'b0; reg_we = 1'b0;
    check_rsp("R8 old", 1'b0, 1'b0, 32'h1234_4004, 7'h3A);
    issue(32'h0010_0000);
    check_rsp("R8 new", 1'b0, 1'b0, 32'hAAAA_0004, 7'h11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule